// File: doc/BRIEF.md
# Paced Single-Channel DMA Engine

This block is one channel of a memory-to-memory and memory-to-device copy engine. Software programs a source address, a destination address and a cycle count through a 16-byte register window, then writes the control word with the enable bit set. The channel then issues a read on the source side and a write on the destination side for every beat. Each side has its own address-step code, and each side can be routed to either the peripheral bus or the system bus. A cycle is a single beat, or four beats when burst mode is set. When the count has run down, the channel stops on its own and raises a completion status.

A transfer can be paced by external request/grant pairs. The source and the destination each name one of fifteen request lines; line number 0 means the side is not paced. While a channel is paced, each cycle waits for its request inputs, and after the cycle's last write the matching grant lines pulse once. An illegal configuration or a bus error response stops the channel with an error status. The count register counts down live, so a read at any time returns the cycles that remain.

Top module: `dmac_channel`

## Requirements
- R1: The register window decodes byte offsets 0 (source address), 4 (destination address), 8 (cycle count, 24 bits) and 12 (control). All four read as zero after reset, and `irq_o` is low.
- R2: For each beat the channel reads from the source address and then writes the data it read to the destination address. The side-select bit for the source is control bit 6 and for the destination is control bit 7 (0 = peripheral bus, 1 = system bus). `m_size_o` carries the width field, control bits 21:20 (00 = 32-bit, 01 = 16-bit, 10 = 8-bit).
- R3: Source step code is control bits 10:8 and destination step code is bits 14:12. They apply per beat: 000 = 0, 001 = +1, 010 = +2, 011 = +4, 101 = −1, 110 = −2, 111 = −4 bytes. The address registers read back the stepped values.
- R4: Burst mode (control bit 3) makes a cycle four beats instead of one, so the address moves by four times the step per cycle. The count register drops by one per completed cycle and reads back the residue while the channel runs.
- R5: When the count reaches zero, the channel sets completion status (bit 1) and clears enable (bit 0) by itself.
- R6: Writing enable while the count is zero sets completion at once and makes no bus access.
- R7: Enabling with step code 100 on either side, or with width code 11, sets error status (bit 4), leaves enable clear and makes no bus access.
- R8: An error response (`m_err_i` with `m_ack_i`) stops the transfer, clears enable and sets error status. The count keeps the cycles that were not completed.
- R9: A nonzero source line (control bits 27:24) or destination line (bits 19:16) holds each cycle until `dreq_i` at that index is high. The cycle then runs, and after its last write `dack_o` at that index is high for exactly one clock. Index 0 is never granted.
- R10: Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. `irq_o` = (bit 1 AND completion enable bit 2) OR (bit 4 AND error enable bit 5).
- R11: While enable is set, writes to the address and count registers and to the control configuration fields are ignored. Status clears and interrupt enables still take effect.
- R12: Once raised, `m_req_o` stays high with stable address and direction until `m_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| m_req_o | output | 1 | Master access request |
| m_we_o | output | 1 | Master access is a write |
| m_sys_o | output | 1 | Access targets system bus (1) or peripheral bus (0) |
| m_size_o | output | 2 | Element width code |
| m_addr_o | output | AW | Master byte address |
| m_wdata_o | output | DW | Master write data |
| m_rdata_i | input | DW | Master read data, valid with ack |
| m_ack_i | input | 1 | Access complete |
| m_err_i | input | 1 | Error response, valid with ack |
| dreq_i | input | 16 | Request lines (index 0 unused) |
| dack_o | output | 16 | Grant pulses (index 0 always low) |
| irq_o | output | 1 | Interrupt |

## Verification
A wrong step or a wrong beat counter shows up in the address registers and in the address of the last write, which the bench reads as soon as the channel goes idle. A wrong count register breaks the residue read taken during a paced stall, which is seen in the same cycle as the read. A broken pacing or grant state shows as writes that happen without a request, or as a grant count that does not match, within one cycle. Faults in the status logic appear on `irq_o` and in the control readback in the first cycle after the triggering event.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR, ST_GNT} seq_st_e;

  localparam int B_EN = 0, B_DONE = 1, B_DIE = 2, B_BURST = 3, B_ERR = 4, B_EIE = 5;
  localparam int B_SSEL = 6, B_DSEL = 7, B_SSTEP = 8, B_DSTEP = 12;
  localparam int B_DLINE = 16, B_WIDTH = 20, B_SLINE = 24;
  localparam int LINE_W = 4;

  function automatic logic code_bad(input logic [2:0] c);
    return c == 3'b100;
  endfunction

  // signed byte step per beat
  function automatic logic [7:0] step_of(input logic [2:0] c);
    logic [7:0] m;
    case (c[1:0])
      2'd0:    m = 8'd0;
      2'd1:    m = 8'd1;
      2'd2:    m = 8'd2;
      default: m = 8'd4;
    endcase
    return c[2] ? (8'd0 - m) : m;
  endfunction
endpackage

// File: rtl/dmac_addr_unit.sv
module dmac_addr_unit #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          adv_i,
  input  logic [2:0]    code_i,
  output logic [AW-1:0] addr_o
);
  import dmac_pkg::*;
  logic [7:0]    s8;
  logic [AW-1:0] step;

  assign s8   = step_of(code_i);
  assign step = {{(AW-8){s8[7]}}, s8};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_val_i;
    else if (adv_i)  addr_o <= addr_o + step;
  end
endmodule

// File: rtl/dmac_pace.sv
module dmac_pace #(
  parameter int LW = 4,
  localparam int NL = 1 << LW
) (
  input  logic [LW-1:0] sline_i,
  input  logic [LW-1:0] dline_i,
  input  logic [NL-1:0] dreq_i,
  input  logic          gnt_i,
  output logic          ready_o,
  output logic          paced_o,
  output logic [NL-1:0] dack_o
);
  logic [LW-1:0] ln [2];
  logic [1:0]    ok;

  assign ln[0] = sline_i;
  assign ln[1] = dline_i;

  for (genvar g = 0; g < 2; g++) begin : g_side
    assign ok[g] = (ln[g] == '0) || dreq_i[ln[g]];
  end

  assign ready_o = &ok;
  assign paced_o = (sline_i != '0) || (dline_i != '0);

  assign dack_o[0] = 1'b0;
  for (genvar k = 1; k < NL; k++) begin : g_ack
    assign dack_o[k] = gnt_i && ((sline_i == LW'(k)) || (dline_i == LW'(k)));
  end
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq #(
  parameter int DW    = 32,
  parameter int BURST = 4,
  localparam int BTW  = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          burst_i,
  input  logic          ready_i,
  input  logic          paced_i,
  input  logic          cnt_one_i,
  input  logic          cnt_zero_i,
  input  logic          m_ack_i,
  input  logic          m_err_i,
  input  logic [DW-1:0] m_rdata_i,
  output logic          m_req_o,
  output logic          m_we_o,
  output logic [DW-1:0] data_o,
  output logic          src_adv_o,
  output logic          dst_adv_o,
  output logic          cyc_dec_o,
  output logic          gnt_o,
  output logic          fin_o,
  output logic          fail_o
);
  import dmac_pkg::*;
  seq_st_e        st_q, st_d;
  logic [BTW-1:0] beat_q;
  logic           last_beat, active;

  assign active    = (st_q == ST_RD) || (st_q == ST_WR);
  assign m_req_o   = active;
  assign m_we_o    = (st_q == ST_WR);
  assign last_beat = beat_q == (burst_i ? BTW'(BURST - 1) : '0);
  assign src_adv_o = (st_q == ST_RD) && m_ack_i && !m_err_i;
  assign dst_adv_o = (st_q == ST_WR) && m_ack_i && !m_err_i;
  assign cyc_dec_o = dst_adv_o && last_beat;
  assign fail_o    = active && m_ack_i && m_err_i;
  assign gnt_o     = (st_q == ST_GNT);
  assign fin_o     = (cyc_dec_o && !paced_i && cnt_one_i) || (gnt_o && cnt_zero_i);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start_i) st_d = ST_WAIT;
      ST_WAIT: if (ready_i) st_d = ST_RD;
      ST_RD:   if (m_ack_i) st_d = m_err_i ? ST_IDLE : ST_WR;
      ST_WR: begin
        if (m_ack_i) begin
          if (m_err_i)        st_d = ST_IDLE;
          else if (!last_beat) st_d = ST_RD;
          else if (paced_i)   st_d = ST_GNT;
          else                st_d = cnt_one_i ? ST_IDLE : ST_WAIT;
        end
      end
      ST_GNT:  st_d = cnt_zero_i ? ST_IDLE : ST_WAIT;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      data_o <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_WAIT)                     beat_q <= '0;
      else if (dst_adv_o && !last_beat)        beat_q <= beat_q + 1'b1;
      if (src_adv_o)                           data_o <= m_rdata_i;
    end
  end
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 24,
  parameter int BURST = 4,
  localparam int RW   = 32,
  localparam int NL   = 1 << dmac_pkg::LINE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [RW-1:0] reg_wdata_i,
  output logic [RW-1:0] reg_rdata_o,
  output logic          m_req_o,
  output logic          m_we_o,
  output logic          m_sys_o,
  output logic [1:0]    m_size_o,
  output logic [AW-1:0] m_addr_o,
  output logic [DW-1:0] m_wdata_o,
  input  logic [DW-1:0] m_rdata_i,
  input  logic          m_ack_i,
  input  logic          m_err_i,
  input  logic [NL-1:0] dreq_i,
  output logic [NL-1:0] dack_o,
  output logic          irq_o
);
  import dmac_pkg::*;
  localparam int LW = LINE_W;

  logic          en_q, done_q, die_q, burst_q, err_q, eie_q, ssel_q, dsel_q;
  logic [2:0]    sstep_q, dstep_q;
  logic [LW-1:0] sline_q, dline_q;
  logic [1:0]    width_q;
  logic [CW-1:0] cnt_q;

  logic          ctl_wr, go_req, cfg_bad, start, zdone, bad_start;
  logic          src_adv, dst_adv, cyc_dec, gnt, fin, fail, ready, paced;
  logic [AW-1:0] addr_q [2];
  logic [1:0]    ld, adv;
  logic [2:0]    code [2];
  logic [RW-1:0] ctrl_word;

  assign ctl_wr    = reg_we_i && (reg_addr_i[3:2] == 2'd3);
  assign go_req    = ctl_wr && !en_q && reg_wdata_i[B_EN];
  assign cfg_bad   = code_bad(reg_wdata_i[B_SSTEP+:3]) || code_bad(reg_wdata_i[B_DSTEP+:3])
                   || (reg_wdata_i[B_WIDTH+:2] == 2'b11);
  assign bad_start = go_req && cfg_bad;
  assign zdone     = go_req && !cfg_bad && (cnt_q == '0);
  assign start     = go_req && !cfg_bad && (cnt_q != '0);

  // address units: 0 = source, 1 = destination
  assign code[0] = sstep_q;
  assign code[1] = dstep_q;
  assign adv     = {dst_adv, src_adv};
  for (genvar g = 0; g < 2; g++) begin : g_addr
    assign ld[g] = reg_we_i && !en_q && (reg_addr_i[3:2] == 2'(g));
    dmac_addr_unit #(.AW(AW)) u_addr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (ld[g]),
      .load_val_i (reg_wdata_i[AW-1:0]),
      .adv_i      (adv[g]),
      .code_i     (code[g]),
      .addr_o     (addr_q[g])
    );
  end

  dmac_pace #(.LW(LW)) u_pace (
    .sline_i (sline_q),
    .dline_i (dline_q),
    .dreq_i  (dreq_i),
    .gnt_i   (gnt),
    .ready_o (ready),
    .paced_o (paced),
    .dack_o  (dack_o)
  );

  dmac_seq #(.DW(DW), .BURST(BURST)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .burst_i    (burst_q),
    .ready_i    (ready),
    .paced_i    (paced),
    .cnt_one_i  (cnt_q == CW'(1)),
    .cnt_zero_i (cnt_q == '0),
    .m_ack_i    (m_ack_i),
    .m_err_i    (m_err_i),
    .m_rdata_i  (m_rdata_i),
    .m_req_o    (m_req_o),
    .m_we_o     (m_we_o),
    .data_o     (m_wdata_o),
    .src_adv_o  (src_adv),
    .dst_adv_o  (dst_adv),
    .cyc_dec_o  (cyc_dec),
    .gnt_o      (gnt),
    .fin_o      (fin),
    .fail_o     (fail)
  );

  assign m_addr_o = m_we_o ? addr_q[1] : addr_q[0];
  assign m_sys_o  = m_we_o ? dsel_q : ssel_q;
  assign m_size_o = width_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; done_q <= 1'b0; die_q <= 1'b0; burst_q <= 1'b0;
      err_q <= 1'b0; eie_q <= 1'b0; ssel_q <= 1'b0; dsel_q <= 1'b0;
      sstep_q <= '0; dstep_q <= '0; sline_q <= '0; dline_q <= '0;
      width_q <= '0; cnt_q <= '0;
    end else begin
      // hardware set wins over a same-cycle software clear
      done_q <= fin | zdone | (done_q & ~(ctl_wr & ~reg_wdata_i[B_DONE]));
      err_q  <= fail | bad_start | (err_q & ~(ctl_wr & ~reg_wdata_i[B_ERR]));
      if (fin || fail)             en_q <= 1'b0;
      else if (ctl_wr && !en_q)    en_q <= start;
      if (ctl_wr) begin
        die_q <= reg_wdata_i[B_DIE];
        eie_q <= reg_wdata_i[B_EIE];
      end
      if (ctl_wr && !en_q) begin
        burst_q <= reg_wdata_i[B_BURST];
        ssel_q  <= reg_wdata_i[B_SSEL];
        dsel_q  <= reg_wdata_i[B_DSEL];
        sstep_q <= reg_wdata_i[B_SSTEP+:3];
        dstep_q <= reg_wdata_i[B_DSTEP+:3];
        dline_q <= reg_wdata_i[B_DLINE+:LW];
        sline_q <= reg_wdata_i[B_SLINE+:LW];
        width_q <= reg_wdata_i[B_WIDTH+:2];
      end
      if (reg_we_i && !en_q && (reg_addr_i[3:2] == 2'd2)) cnt_q <= reg_wdata_i[CW-1:0];
      else if (cyc_dec)                                    cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_EN]    = en_q;
    ctrl_word[B_DONE]  = done_q;
    ctrl_word[B_DIE]   = die_q;
    ctrl_word[B_BURST] = burst_q;
    ctrl_word[B_ERR]   = err_q;
    ctrl_word[B_EIE]   = eie_q;
    ctrl_word[B_SSEL]  = ssel_q;
    ctrl_word[B_DSEL]  = dsel_q;
    ctrl_word[B_SSTEP+:3]  = sstep_q;
    ctrl_word[B_DSTEP+:3]  = dstep_q;
    ctrl_word[B_DLINE+:LW] = dline_q;
    ctrl_word[B_WIDTH+:2]  = width_q;
    ctrl_word[B_SLINE+:LW] = sline_q;
  end

  always_comb begin
    case (reg_addr_i[3:2])
      2'd0:    reg_rdata_o = RW'(addr_q[0]);
      2'd1:    reg_rdata_o = RW'(addr_q[1]);
      2'd2:    reg_rdata_o = RW'(cnt_q);
      default: reg_rdata_o = ctrl_word;
    endcase
  end

  assign irq_o = (done_q & die_q) | (err_q & eie_q);
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int NL = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          m_req_o,
  input logic          m_we_o,
  input logic [AW-1:0] m_addr_o,
  input logic          m_ack_i,
  input logic          m_err_i,
  input logic [NL-1:0] dack_o,
  input logic          en_i,
  input logic          done_i,
  input logic [CW-1:0] cnt_i
);
  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && !m_ack_i) |=> (m_req_o && $stable(m_addr_o) && $stable(m_we_o)));

  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> ((cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) - 1'b1)));

  p_done_stops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> !en_i);

  p_quiet_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !m_req_o);

  p_err_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && m_ack_i && m_err_i) |=> (!en_i && !m_req_o));

  p_line0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dack_o[0]);

  p_gnt_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dack_o) |=> !(|dack_o));

  p_gnt_lines_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dack_o) <= 2);
endmodule

bind dmac_channel dmac_chk #(.AW(AW), .CW(CW), .NL(NL)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .m_req_o  (m_req_o),
  .m_we_o   (m_we_o),
  .m_addr_o (m_addr_o),
  .m_ack_i  (m_ack_i),
  .m_err_i  (m_err_i),
  .dack_o   (dack_o),
  .en_i     (en_q),
  .done_i   (done_q),
  .cnt_i    (cnt_q)
);

// File: tb/tb_dmac_channel.sv
module tb_dmac_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        m_req, m_we, m_sys;
  logic [1:0]  m_size;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic        ack_q = 1'b0;
  logic        err_inj = 1'b0;
  logic        m_err;
  logic [15:0] dreq = '0;
  logic [15:0] dack;
  logic        irq;

  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, dack_cnt = 0, dack_bad = 0, hold_bad = 0;
  logic [31:0] last_wa, last_wd;
  logic        last_sys;
  logic [1:0]  last_size;
  logic        prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;

  always #5 clk = ~clk;

  dmac_channel dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .m_req_o(m_req),
    .m_we_o(m_we), .m_sys_o(m_sys), .m_size_o(m_size), .m_addr_o(m_addr),
    .m_wdata_o(m_wdata), .m_rdata_i(m_rdata), .m_ack_i(ack_q), .m_err_i(m_err),
    .dreq_i(dreq), .dack_o(dack), .irq_o(irq)
  );

  // responder: data encodes side and address
  assign m_rdata = {m_sys ? 16'hC0DE : 16'h0E0E, m_addr[15:0]};
  assign m_err   = ack_q & err_inj;

  always_ff @(posedge clk) begin
    ack_q <= m_req && !ack_q;
    if (m_req && m_we && ack_q && !err_inj) begin
      wr_cnt    <= wr_cnt + 1;
      last_wa   <= m_addr;
      last_wd   <= m_wdata;
      last_sys  <= m_sys;
      last_size <= m_size;
    end
    if (dack[3]) dack_cnt <= dack_cnt + 1;
    if ((dack & ~16'h0008) != 0) dack_bad <= dack_bad + 1;
    if (prev_pend && m_addr != prev_addr) hold_bad <= hold_bad + 1;
    prev_pend <= m_req && !ack_q;
    prev_addr <= m_addr;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] c;
    for (int i = 0; i < 2000; i++) begin
      rd(4'd12, c);
      if (!c[0]) return;
    end
    chk({tag, " timeout"}, 32'd1, 32'd0);
  endtask

  // ctrl, src, dst, cnt, exp_src, exp_dst, exp_writes, exp_last_addr, exp_last_data
  localparam logic [31:0] VEC [4][9] = '{
    '{32'h0020_3141, 32'h100,  32'h200,  32'd3, 32'h103,  32'h20C,  32'd3, 32'h208,  32'hC0DE_0102},
    '{32'h0000_7389, 32'h1000, 32'h2000, 32'd2, 32'h1020, 32'h1FE0, 32'd8, 32'h1FE4, 32'h0E0E_101C},
    '{32'h0010_00C1, 32'h40,   32'h80,   32'd4, 32'h40,   32'h80,   32'd4, 32'h80,   32'hC0DE_0040},
    '{32'h0010_6209, 32'h300,  32'h400,  32'd1, 32'h308,  32'h3F8,  32'd4, 32'h3FA,  32'h0E0E_0306}
  };

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), v);
      chk("R1 reset reg", v, 32'h0);
    end
    chk("R1 reset irq", {31'b0, irq}, 32'h0);

    // vector walk: R2 R3 R4 R5
    for (int i = 0; i < 4; i++) begin
      wr(4'd12, 32'h0);
      wr(4'd0, VEC[i][1]);
      wr(4'd4, VEC[i][2]);
      wr(4'd8, VEC[i][3]);
      base = wr_cnt;
      wr(4'd12, VEC[i][0]);
      wait_idle("R5 vec");
      rd(4'd12, v);
      chk("R5 done set", {30'b0, v[1:0]}, 32'h2);
      rd(4'd8, v);
      chk("R4 count zero", v, 32'h0);
      rd(4'd0, v);
      chk("R3 src final", v, VEC[i][4]);
      rd(4'd4, v);
      chk("R3 dst final", v, VEC[i][5]);
      chk("R4 beats", 32'(wr_cnt - base), VEC[i][6]);
      chk("R3 last write addr", last_wa, VEC[i][7]);
      chk("R2 data and src side", last_wd, VEC[i][8]);
      chk("R2 dst side", {31'b0, last_sys}, {31'b0, VEC[i][0][7]});
      chk("R2 size", {30'b0, last_size}, {30'b0, VEC[i][0][21:20]});
    end

    // R6 zero count
    wr(4'd12, 32'h0);
    wr(4'd8, 32'h0);
    base = wr_cnt;
    wr(4'd12, 32'h0000_0005);
    rd(4'd12, v);
    chk("R6 zero count done", {30'b0, v[1:0]}, 32'h2);
    chk("R10 done irq", {31'b0, irq}, 32'h1);
    repeat (5) @(negedge clk);
    chk("R6 no access", 32'(wr_cnt - base), 32'h0);
    wr(4'd12, 32'h0000_0004);
    rd(4'd12, v);
    chk("R10 w0c done", {31'b0, v[1]}, 32'h0);
    chk("R10 irq clear", {31'b0, irq}, 32'h0);

    // R7 illegal codes
    wr(4'd8, 32'd2);
    base = wr_cnt;
    wr(4'd12, 32'h0000_0401);
    rd(4'd12, v);
    chk("R7 step 100 err", {27'b0, v[4], 3'b0, v[0]}, 32'h10);
    wr(4'd12, 32'h0);
    wr(4'd12, 32'h0030_0001);
    rd(4'd12, v);
    chk("R7 width 11 err", {27'b0, v[4], 3'b0, v[0]}, 32'h10);
    repeat (5) @(negedge clk);
    chk("R7 no access", 32'(wr_cnt - base), 32'h0);

    // R8 bus error
    wr(4'd12, 32'h0);
    wr(4'd8, 32'd3);
    err_inj = 1'b1;
    base = wr_cnt;
    wr(4'd12, 32'h0000_0021);
    wait_idle("R8");
    err_inj = 1'b0;
    rd(4'd12, v);
    chk("R8 err set", {27'b0, v[4], 3'b0, v[0]}, 32'h10);
    rd(4'd8, v);
    chk("R8 count kept", v, 32'd3);
    chk("R8 no write", 32'(wr_cnt - base), 32'h0);
    chk("R10 err irq", {31'b0, irq}, 32'h1);
    wr(4'd12, 32'h0000_0020);
    chk("R10 err irq clear", {31'b0, irq}, 32'h0);

    // R9 pacing on source line 3, R11 writes ignored while running
    wr(4'd12, 32'h0);
    wr(4'd0, 32'h500);
    wr(4'd8, 32'd2);
    base = wr_cnt;
    wr(4'd12, 32'h0300_0001);
    repeat (20) @(negedge clk);
    chk("R9 stalled no write", 32'(wr_cnt - base), 32'h0);
    wr(4'd0, 32'h999);
    wr(4'd8, 32'd7);
    rd(4'd0, v);
    chk("R11 src write ignored", v, 32'h500);
    rd(4'd8, v);
    chk("R11 count write ignored", v, 32'd2);
    dreq[3] = 1'b1;
    for (int i = 0; i < 200 && dack_cnt == 0; i++) @(negedge clk);
    dreq[3] = 1'b0;
    repeat (10) @(negedge clk);
    rd(4'd8, v);
    chk("R4 residue", v, 32'd1);
    chk("R9 one cycle", 32'(wr_cnt - base), 32'd1);
    dreq[3] = 1'b1;
    wait_idle("R9");
    dreq[3] = 1'b0;
    chk("R9 grants", 32'(dack_cnt), 32'd2);
    chk("R9 stray grants", 32'(dack_bad), 32'd0);
    chk("R12 request hold", 32'(hold_bad), 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule